// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for every cycle of a four-beat burst in a synchronous burst memory. A burst opens when one of two active-low address strobes is sampled at a rising clock edge. One strobe belongs to a processor and the other to a cache controller. The generator then registers the presented address as the burst base. On later cycles the two least significant address bits move to the next beat, but only when the active-low advance input is sampled low. The upper address bits always come from the registered base. A static order input chooses the beat order: an incrementing count, or an order in which the beat number is XORed into the starting low bits.

The two strobes are qualified by three chip enables, which differ in polarity. The processor strobe needs only the primary enable. The controller strobe needs all three enables. A second output stays high for the one cycle that follows each accepted strobe, so a downstream array can tell a fresh base from a stepped beat. The memory array and the data path are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: With `cs_n` low, a low `ads_proc_n` at a rising edge loads `addr_in`, and `addr_out` equals it after that edge. The states of `cs_p` and `cs2_n` do not matter for this strobe.
- R2: With `cs_n` high, a low `ads_proc_n` is ignored: `addr_out` keeps its value and `load_q` stays low.
- R3: A low `ads_ctrl_n` loads `addr_in` only when `cs_n` is low, `cs_p` is high and `cs2_n` is low. Under any other enable pattern it is ignored.
- R4: `load_q` is high during exactly the cycle that follows an edge where a strobe was accepted, and low at all other times.
- R5: With `mode_ileave` low (linear order), beat n places (start + n) mod 4 on `addr_out[1:0]`, where start is the loaded low two bits.
- R6: With `mode_ileave` high (interleaved order), beat n places start XOR n on `addr_out[1:0]`. A start of 1 gives 1,0,3,2.
- R7: After four advances the low bits return to the start value. They never carry into `addr_out[AW-1:2]`.
- R8: If a strobe is accepted in the same cycle that `adv_n` is low, the strobe wins and the beat count restarts at 0 from the new base.
- R9: When no strobe is accepted and `adv_n` is high, `addr_out` holds its value.
- R10: A synchronous active-high `rst` clears `addr_out` to 0 and `load_q` to 0.
- R11: `addr_out[AW-1:2]` changes only on an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | AW | Address presented with a strobe |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode_ileave | input | 1 | Burst order: 0 for linear, 1 for interleaved |
| cs_n | input | 1 | Primary chip enable, active low |
| cs_p | input | 1 | Secondary chip enable, active high |
| cs2_n | input | 1 | Tertiary chip enable, active low |
| addr_out | output | AW | Current burst word address |
| load_q | output | 1 | High in the cycle after a base load |

## Verification
Directed bursts run from every start value under both orders. Advancing four times shows whether the sequence wraps or wrongly carries into the upper bits. It also separates XOR stepping from addition, since the two agree only for some start values. Each enable polarity is flipped on its own while each strobe is applied, which shows that the processor strobe depends only on the primary enable and that the controller strobe needs all three. A random phase then mixes strobes, advances, idle cycles and overlapping strobe-plus-advance cycles against a bench model. This exposes any wrong priority between load and step, and any drift of the held address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int LOW_W   = 2;
    localparam int BEAT_W  = LOW_W;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic step;
    } burst_ctl_t;

    function automatic logic [LOW_W-1:0] beat_low(
        input logic [LOW_W-1:0]  start,
        input logic [BEAT_W-1:0] beat,
        input order_e            ord
    );
        logic [LOW_W-1:0] r;
        if (ord == ORDER_XOR) r = start ^ beat;
        else                  r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/bsg_strobe_qual.sv
module bsg_strobe_qual
    import burst_seq_pkg::*;
(
    input  logic       ads_proc_n,
    input  logic       ads_ctrl_n,
    input  logic       adv_n,
    input  logic       cs_n,
    input  logic       cs_p,
    input  logic       cs2_n,
    output burst_ctl_t ctl
);
    logic proc_ok;
    logic ctrl_ok;

    always_comb begin
        proc_ok  = !ads_proc_n && !cs_n;
        ctrl_ok  = !ads_ctrl_n && !cs_n && cs_p && !cs2_n;
        ctl.load = proc_ok || ctrl_ok;
        ctl.step = !adv_n && !(proc_ok || ctrl_ok);
    end
endmodule

// File: rtl/bsg_beat_counter.sv
module bsg_beat_counter
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  burst_ctl_t        ctl,
    output logic [BEAT_W-1:0] beat
);
    always_ff @(posedge clk) begin
        if (rst)           beat <= '0;
        else if (ctl.load) beat <= '0;
        else if (ctl.step) beat <= beat + 1'b1;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_in,
    input  logic          ads_proc_n,
    input  logic          ads_ctrl_n,
    input  logic          adv_n,
    input  logic          mode_ileave,
    input  logic          cs_n,
    input  logic          cs_p,
    input  logic          cs2_n,
    output logic [AW-1:0] addr_out,
    output logic          load_q
);
    localparam int HI_W = AW - LOW_W;

    burst_ctl_t        ctl;
    logic [BEAT_W-1:0] beat;
    logic [AW-1:0]     base_q;
    order_e            ord;

    bsg_strobe_qual u_qual (
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .adv_n      (adv_n),
        .cs_n       (cs_n),
        .cs_p       (cs_p),
        .cs2_n      (cs2_n),
        .ctl        (ctl)
    );

    bsg_beat_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .beat (beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= ctl.load;
            if (ctl.load) base_q <= addr_in;
        end
    end

    always_comb begin
        ord      = order_e'(mode_ileave);
        addr_out = {base_q[AW-1 -: HI_W], beat_low(base_q[LOW_W-1:0], beat, ord)};
    end
endmodule

// File: rtl/bsg_checker.sv
module bsg_checker #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr_in,
    input logic          ads_proc_n,
    input logic          ads_ctrl_n,
    input logic          adv_n,
    input logic          mode_ileave,
    input logic          cs_n,
    input logic          cs_p,
    input logic          cs2_n,
    input logic [AW-1:0] addr_out,
    input logic          load_q
);
    logic take;
    assign take = (!ads_proc_n && !cs_n) || (!ads_ctrl_n && !cs_n && cs_p && !cs2_n);

    assert_load_addr_R1: assert property (@(posedge clk) disable iff (rst)
        take |=> addr_out == $past(addr_in));

    assert_load_flag_R4: assert property (@(posedge clk) disable iff (rst)
        take |=> load_q);

    assert_no_flag_R4: assert property (@(posedge clk) disable iff (rst)
        !take |=> !load_q);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!take && adv_n) |=> (!$stable(mode_ileave) || addr_out == $past(addr_out)));

    assert_upper_R11: assert property (@(posedge clk) disable iff (rst)
        !take |=> addr_out[AW-1:2] == $past(addr_out[AW-1:2]));

    assert_linear_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!take && !adv_n && !mode_ileave) |=>
            (mode_ileave || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));
endmodule

bind burst_addr_seq bsg_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_in     (addr_in),
    .ads_proc_n  (ads_proc_n),
    .ads_ctrl_n  (ads_ctrl_n),
    .adv_n       (adv_n),
    .mode_ileave (mode_ileave),
    .cs_n        (cs_n),
    .cs_p        (cs_p),
    .cs2_n       (cs2_n),
    .addr_out    (addr_out),
    .load_q      (load_q)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
    logic          mode_ileave = 1'b0;
    logic          cs_n = 1'b0, cs_p = 1'b1, cs2_n = 1'b0;
    logic [AW-1:0] addr_out;
    logic          load_q;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] e_base = '0;
    logic [1:0]    e_beat = '0;
    logic          e_load = 1'b0;

    always #5 clk = ~clk;

    burst_addr_seq #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
        .mode_ileave(mode_ileave), .cs_n(cs_n), .cs_p(cs_p), .cs2_n(cs2_n),
        .addr_out(addr_out), .load_q(load_q)
    );

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] n, logic m);
        logic [1:0] lo;
        lo = m ? (b[1:0] ^ n) : (b[1:0] + n);
        return {b[AW-1:2], lo};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive inputs, update model, sample after the edge
    task automatic step(input logic [AW-1:0] a, input logic pn, input logic cn,
                        input logic av, input logic c0, input logic c1, input logic c2,
                        input string tag);
        logic take;
        addr_in = a; ads_proc_n = pn; ads_ctrl_n = cn; adv_n = av;
        cs_n = c0; cs_p = c1; cs2_n = c2;
        take = (!pn && !c0) || (!cn && !c0 && c1 && !c2);
        if (take) begin e_base = a; e_beat = 2'd0; end
        else if (!av) e_beat = e_beat + 2'd1;
        e_load = take;
        @(posedge clk); #1;
        check(addr_out === exp_addr(e_base, e_beat, mode_ileave), tag, addr_out, exp_addr(e_base, e_beat, mode_ileave));
        check(load_q === e_load, {tag, " load_q"}, AW'(load_q), AW'(e_load));
    endtask

    task automatic burst(input logic [AW-1:0] a, input logic m);
        mode_ileave = m;
        step(a, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R1");
        for (int k = 0; k < 4; k++) begin
            if (m) step('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
            else   step('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
        end
        // four advances: back at start, upper bits unchanged
        check(addr_out === a, "R7", addr_out, a);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(posedge clk); #1;
        @(posedge clk); #1;
        check(addr_out === '0, "R10", addr_out, '0);
        check(load_q === 1'b0, "R10 load_q", AW'(load_q), '0);
        rst = 1'b0;

        // R5/R6/R7: every start value in both orders
        for (int s = 0; s < 4; s++) begin
            burst({16'hA5C3, 2'(s)}, 1'b0);
            burst({16'h3C5A, 2'(s)}, 1'b1);
        end
        // R6 directed: start 1 gives 1,0,3,2
        mode_ileave = 1'b1;
        step(18'h00001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R1");
        step('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
        check(addr_out[1:0] === 2'd0, "R6 beat1", AW'(addr_out[1:0]), '0);
        step('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
        check(addr_out[1:0] === 2'd3, "R6 beat2", AW'(addr_out[1:0]), 18'd3);

        // R1: processor strobe ignores the secondary enables
        step(18'h12345, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
        // R2: processor strobe with primary enable off
        step(18'h2FFFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
        check(addr_out === 18'h12345, "R2 held", addr_out, 18'h12345);
        // R3: controller strobe under each single enable failure, then all good
        step(18'h01111, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
        step(18'h02222, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        step(18'h03333, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
        check(addr_out === 18'h12345, "R3 ignored", addr_out, 18'h12345);
        step(18'h04446, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
        check(addr_out === 18'h04446, "R3 loaded", addr_out, 18'h04446);
        // R4: flag lasts one cycle; R9: hold
        step('0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
        step('0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
        // R8: strobe and advance together
        step('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        step(18'h3AAA9, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        check(addr_out === 18'h3AAA9, "R8 restart", addr_out, 18'h3AAA9);

        // random phase (R11 covered by the model on every step)
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            logic pn, cn, av, c0, c1, c2;
            a  = AW'($urandom);
            pn = ($urandom % 5) != 0;
            cn = ($urandom % 5) != 0;
            av = ($urandom % 3) == 0;
            c0 = ($urandom % 6) == 0;
            c1 = ($urandom % 6) != 0;
            c2 = ($urandom % 6) == 0;
            if (($urandom % 50) == 0) mode_ileave = ~mode_ileave;
            step(a, pn, cn, av, c0, c1, c2, "R11");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule